// File: doc/BRIEF.md
# Paged 8-bit Host to ISA Card Bridge

This block lets a small 8-bit host with a 6502-style bus drive an ISA expansion card through a 512-byte slot in its I/O map. Host address bit 8 splits the slot into two halves. The lower half is a 256-byte swap window onto card space. The upper half holds the bridge's own registers. The ISA address bits above the window come from two write-only page registers. The top bit of the upper page register chooses between ISA I/O space and ISA memory space. Its next bit marks a 16-bit transfer.

Command strobes are produced combinationally from the host select, the bus-available flag, the phase-2 clock, the host read/write line and the space bit. A second pair of memory strobes serves the 8-bit connector of a 16-bit slot. This pair stays quiet when the two highest address bits are not zero. The card's interrupt requests are merged into one active-low host interrupt, and the pending lines can be read back from two status bytes. Two upper-data-byte latches let the 8-bit host move 16-bit words: one latch for data going to the card, one for data coming back.

The block works on one system clock with a synchronous active-low reset. That reset is also the host reset.

Top module: `host_isa_bridge`

## Requirements
- R1: During a swap-window access (`host_addr[8]`=0, `host_sel_n`=0, `host_ba`=1, `host_phi2`=1), exactly one full command strobe is low. Page bit 7 = 1 selects I/O space (`isa_ior_n` on a read, `isa_iow_n` on a write). Page bit 7 = 0 selects memory space (`isa_memr_n` / `isa_memw_n`). `host_rw`=1 means read.
- R2: All command strobes, legacy strobes and data drive enables are inactive whenever `host_sel_n`=1, `host_ba`=0, `host_phi2`=0 or `host_addr[8]`=1.
- R3: `isa_addr` equals {upper page bits [5:0], lower page register, `host_addr[7:0]`}. `isa_sbhe_n` is the inverse of upper page bit 6.
- R4: The register half decodes offsets 0x00 (lower page, write), 0x01 (upper page, write), 0x02 and 0x03 (status, read) and 0x04 (upper-byte latches). Reads at 0x00, 0x01 and at every unused offset return zero.
- R5: `isa_reset_drv` is high exactly while `rst_n` is low, and `isa_aen` is always low. After reset both page registers and both upper-byte latches are zero and `host_irq_n` is high.
- R6: One clock after any `isa_irq_req` line is high, `host_irq_n` is low. One clock after all lines are low, it is high. The status byte at 0x02 holds request lines [7:0] and the byte at 0x03 holds lines [10:8] in bits [2:0], with zeros above. Both bytes show the lines as sampled on the previous clock. Line index 0..5 is IRQ2..IRQ7 and index 6..10 is IRQ10..IRQ14.
- R7: A host write to offset 0x04 loads the outbound upper-byte latch. The latch is shown on `isa_d_hi_out` and keeps its value through every other access. `isa_d_hi_oe` is high exactly during a card write strobe.
- R8: The inbound upper-byte latch captures `isa_d_hi_in` on each clock edge during a card read strobe, and otherwise keeps its value. The host reads it at offset 0x04.
- R9: `isa_d_lo_oe` is high only during a card write strobe, and `isa_d_lo_out` then equals `host_wdata`. During a card read, `host_rdata` equals `isa_d_lo_in`.
- R10: `isa_smemr_n` and `isa_smemw_n` follow the full memory strobes only while upper page bits [5:4] (address bits 21..20) are zero. Otherwise they stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, also the host reset |
| host_sel_n | input | 1 | Active-low select of the 512-byte slot |
| host_addr | input | 9 | Host address within the slot |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_phi2 | input | 1 | Host phase-2 clock qualifying data transfer |
| host_ba | input | 1 | Host bus available |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_irq_n | output | 1 | Merged active-low interrupt |
| isa_addr | output | 22 | ISA address |
| isa_sbhe_n | output | 1 | Active-low byte-high enable |
| isa_ior_n | output | 1 | I/O read strobe |
| isa_iow_n | output | 1 | I/O write strobe |
| isa_memr_n | output | 1 | Full memory read strobe |
| isa_memw_n | output | 1 | Full memory write strobe |
| isa_smemr_n | output | 1 | Legacy-range memory read strobe |
| isa_smemw_n | output | 1 | Legacy-range memory write strobe |
| isa_reset_drv | output | 1 | Active-high card reset |
| isa_aen | output | 1 | Address enable, held low |
| isa_d_lo_out | output | 8 | Low data byte toward the card |
| isa_d_lo_oe | output | 1 | Drive enable for the low data byte |
| isa_d_lo_in | input | 8 | Low data byte from the card |
| isa_d_hi_out | output | 8 | Outbound upper-byte latch |
| isa_d_hi_oe | output | 1 | Drive enable for the upper data byte |
| isa_d_hi_in | input | 8 | Upper data byte from the card |
| isa_irq_req | input | 11 | Active-high card interrupt requests |

## Verification
A wrong space bit or a bad decode shows at once, in the same cycle, as the wrong strobe or as two strobes together. So the bench sweeps every combination of select, bus-available, phase-2, half select and read/write under both space settings and both legacy-range settings. A corrupted page register shows on `isa_addr` on the cycle after the write. A latch that loses or picks up data shows only when the host reads offset 0x04 or when the next card write drives the upper byte. The bench therefore runs unrelated cycles before it reads the latches back. An interrupt path fault shows one clock after a request changes, both on `host_irq_n` and in the status bytes.

// File: rtl/isab_pkg.sv
// Shared constants and types for the paged host-to-ISA bridge.
// Assumes an 8-bit register offset inside the upper half of the slot.
package isab_pkg;
    localparam logic [7:0] OFS_PAGE_LO = 8'h00;
    localparam logic [7:0] OFS_PAGE_HI = 8'h01;
    localparam logic [7:0] OFS_STAT_LO = 8'h02;
    localparam logic [7:0] OFS_STAT_HI = 8'h03;
    localparam logic [7:0] OFS_HI_BYTE = 8'h04;

    // bit positions inside the upper page register
    localparam int SBHE_BIT  = 6;
    localparam int SPACE_BIT = 7;

    // one decoded host access; at most one field is set
    typedef struct packed {
        logic card_rd;
        logic card_wr;
        logic reg_rd;
        logic reg_wr;
    } isab_access_t;
endpackage

// File: rtl/isab_decode.sv
// Access decoder and command strobe generator.
// Purely combinational. Assumes the host inputs are stable while phase-2
// is high, which holds for a 6502-style bus.
module isab_decode
    import isab_pkg::*;
(
    input  logic         sel_n,
    input  logic         ba,
    input  logic         phi2,
    input  logic         rw,
    input  logic         upper_half,
    input  logic         space_io,
    input  logic         legacy_ok,
    output isab_access_t acc,
    output logic         ior_n,
    output logic         iow_n,
    output logic         memr_n,
    output logic         memw_n,
    output logic         smemr_n,
    output logic         smemw_n
);
    logic live;

    // qualify the host cycle and split it into the four access kinds
    always_comb begin
        live        = !sel_n && ba && phi2;
        acc.card_rd = live && !upper_half && rw;
        acc.card_wr = live && !upper_half && !rw;
        acc.reg_rd  = live && upper_half && rw;
        acc.reg_wr  = live && upper_half && !rw;
    end

    // steer the card access to the strobe of the selected space
    always_comb begin
        ior_n   = !(acc.card_rd && space_io);
        iow_n   = !(acc.card_wr && space_io);
        memr_n  = !(acc.card_rd && !space_io);
        memw_n  = !(acc.card_wr && !space_io);
        smemr_n = memr_n || !legacy_ok;
        smemw_n = memw_n || !legacy_ok;
    end
endmodule

// File: rtl/isab_regs.sv
// Page registers and upper-data-byte latches.
// Registers load on any clock edge inside a qualified host cycle. Repeated
// loads within one phase-2 period store the same value.
module isab_regs
    import isab_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  isab_access_t      acc,
    input  logic [7:0]        offset,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] d_hi_in,
    output logic [DATA_W-1:0] page_lo,
    output logic [DATA_W-1:0] page_hi,
    output logic [DATA_W-1:0] hi_out_q,
    output logic [DATA_W-1:0] hi_in_q
);
    // host writes to the page registers and the outbound latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_lo  <= '0;
            page_hi  <= '0;
            hi_out_q <= '0;
        end else if (acc.reg_wr) begin
            if (offset == OFS_PAGE_LO) page_lo  <= wdata;
            if (offset == OFS_PAGE_HI) page_hi  <= wdata;
            if (offset == OFS_HI_BYTE) hi_out_q <= wdata;
        end
    end

    // the inbound latch captures the card's upper byte during card reads only
    always_ff @(posedge clk) begin
        if (!rst_n)           hi_in_q <= '0;
        else if (acc.card_rd) hi_in_q <= d_hi_in;
    end
endmodule

// File: rtl/isab_irq.sv
// Interrupt sampler and merger.
// Registers the request lines once and drives a single active-low request.
// Assumes the requests are level signals that are held until serviced.
module isab_irq #(
    parameter int IRQ_N = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] irq_req,
    output logic [IRQ_N-1:0] irq_q,
    output logic             irq_n
);
    // sample the lines and form the merged request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            irq_n <= 1'b1;
        end else begin
            irq_q <= irq_req;
            irq_n <= ~|irq_req;
        end
    end
endmodule

// File: rtl/host_isa_bridge.sv
// Top of the paged host-to-ISA bridge.
// Assembles the ISA address from the page registers and the host's low
// address byte, muxes host read data and fixes reset and AEN.
// Assumes one clock domain and that the host reset is rst_n.
module host_isa_bridge
    import isab_pkg::*;
#(
    parameter int WIN_W     = 8,
    parameter int DATA_W    = 8,
    parameter int EXT_W     = 6,
    parameter int LEGACY_AW = 20,
    parameter int IRQ_N     = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_sel_n,
    input  logic [WIN_W:0]             host_addr,
    input  logic                       host_rw,
    input  logic                       host_phi2,
    input  logic                       host_ba,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       host_irq_n,
    output logic [WIN_W+DATA_W+EXT_W-1:0] isa_addr,
    output logic                       isa_sbhe_n,
    output logic                       isa_ior_n,
    output logic                       isa_iow_n,
    output logic                       isa_memr_n,
    output logic                       isa_memw_n,
    output logic                       isa_smemr_n,
    output logic                       isa_smemw_n,
    output logic                       isa_reset_drv,
    output logic                       isa_aen,
    output logic [DATA_W-1:0]          isa_d_lo_out,
    output logic                       isa_d_lo_oe,
    input  logic [DATA_W-1:0]          isa_d_lo_in,
    output logic [DATA_W-1:0]          isa_d_hi_out,
    output logic                       isa_d_hi_oe,
    input  logic [DATA_W-1:0]          isa_d_hi_in,
    input  logic [IRQ_N-1:0]           isa_irq_req
);
    localparam int LEG_LO = LEGACY_AW - WIN_W - DATA_W;
    localparam int STAT_W = 2 * DATA_W;

    isab_access_t      acc;
    logic [DATA_W-1:0] page_lo, page_hi, hi_out_q, hi_in_q;
    logic [IRQ_N-1:0]  irq_q;
    logic [STAT_W-1:0] stat;
    logic              legacy_ok;

    // address bits 21..20 must be zero for the legacy connector
    assign legacy_ok = (page_hi[EXT_W-1:LEG_LO] == '0);

    isab_decode u_dec (
        .sel_n      (host_sel_n),
        .ba         (host_ba),
        .phi2       (host_phi2),
        .rw         (host_rw),
        .upper_half (host_addr[WIN_W]),
        .space_io   (page_hi[SPACE_BIT]),
        .legacy_ok  (legacy_ok),
        .acc        (acc),
        .ior_n      (isa_ior_n),
        .iow_n      (isa_iow_n),
        .memr_n     (isa_memr_n),
        .memw_n     (isa_memw_n),
        .smemr_n    (isa_smemr_n),
        .smemw_n    (isa_smemw_n)
    );

    isab_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .offset   (host_addr[7:0]),
        .wdata    (host_wdata),
        .d_hi_in  (isa_d_hi_in),
        .page_lo  (page_lo),
        .page_hi  (page_hi),
        .hi_out_q (hi_out_q),
        .hi_in_q  (hi_in_q)
    );

    isab_irq #(.IRQ_N(IRQ_N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (isa_irq_req),
        .irq_q   (irq_q),
        .irq_n   (host_irq_n)
    );

    // fixed card-side outputs and address assembly
    always_comb begin
        isa_addr      = {page_hi[EXT_W-1:0], page_lo, host_addr[WIN_W-1:0]};
        isa_sbhe_n    = !page_hi[SBHE_BIT];
        isa_reset_drv = !rst_n;
        isa_aen       = 1'b0;
        isa_d_lo_out  = host_wdata;
        isa_d_lo_oe   = acc.card_wr;
        isa_d_hi_out  = hi_out_q;
        isa_d_hi_oe   = acc.card_wr;
        stat          = STAT_W'(irq_q);
    end

    // host read data: card byte in the swap half, registers in the upper half
    always_comb begin
        host_rdata = '0;
        if (acc.card_rd) begin
            host_rdata = isa_d_lo_in;
        end else if (acc.reg_rd) begin
            case (host_addr[7:0])
                OFS_STAT_LO: host_rdata = stat[DATA_W-1:0];
                OFS_STAT_HI: host_rdata = stat[STAT_W-1:DATA_W];
                OFS_HI_BYTE: host_rdata = hi_in_q;
                default:     host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/isab_chk.sv
// Assertion checker for host_isa_bridge, attached by bind below.
// Observes ports plus the inbound latch state; drives nothing.
module isab_chk #(
    parameter int IRQ_N  = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              ba,
    input logic              phi2,
    input logic              upper_half,
    input logic              ior_n,
    input logic              iow_n,
    input logic              memr_n,
    input logic              memw_n,
    input logic              smemr_n,
    input logic              smemw_n,
    input logic              d_lo_oe,
    input logic              d_hi_oe,
    input logic [IRQ_N-1:0]  irq_req,
    input logic              irq_n,
    input logic [DATA_W-1:0] hi_in_q
);
    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ior_n, ~iow_n, ~memr_n, ~memw_n}));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !ba || !phi2 || upper_half) |->
        (ior_n && iow_n && memr_n && memw_n && smemr_n && smemw_n && !d_lo_oe && !d_hi_oe));

    // R9
    lo_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_lo_oe |-> (!iow_n || !memw_n));

    // R10
    legacy_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smemr_n |-> !memr_n) and (!smemw_n |-> !memw_n));

    // R6
    irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |=> !irq_n);

    // R6
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq_req) |=> irq_n);

    // R8
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ior_n && memr_n) |=> $stable(hi_in_q));
endmodule

bind host_isa_bridge isab_chk #(.IRQ_N(IRQ_N), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (host_sel_n),
    .ba         (host_ba),
    .phi2       (host_phi2),
    .upper_half (host_addr[WIN_W]),
    .ior_n      (isa_ior_n),
    .iow_n      (isa_iow_n),
    .memr_n     (isa_memr_n),
    .memw_n     (isa_memw_n),
    .smemr_n    (isa_smemr_n),
    .smemw_n    (isa_smemw_n),
    .d_lo_oe    (isa_d_lo_oe),
    .d_hi_oe    (isa_d_hi_oe),
    .irq_req    (isa_irq_req),
    .irq_n      (host_irq_n),
    .hi_in_q    (hi_in_q)
);

// File: tb/host_isa_bridge_tb_top.sv
`timescale 1ns/1ps
module host_isa_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel_n = 1'b1;
    logic [8:0]  host_addr = '0;
    logic        host_rw = 1'b1;
    logic        host_phi2 = 1'b0;
    logic        host_ba = 1'b1;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_irq_n;
    logic [21:0] isa_addr;
    logic        isa_sbhe_n, isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n;
    logic        isa_smemr_n, isa_smemw_n, isa_reset_drv, isa_aen;
    logic [7:0]  isa_d_lo_out, isa_d_hi_out;
    logic        isa_d_lo_oe, isa_d_hi_oe;
    logic [7:0]  isa_d_lo_in = '0;
    logic [7:0]  isa_d_hi_in = '0;
    logic [10:0] isa_irq_req = '0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    host_isa_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_addr(host_addr),
        .host_rw(host_rw), .host_phi2(host_phi2), .host_ba(host_ba),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq_n(host_irq_n),
        .isa_addr(isa_addr), .isa_sbhe_n(isa_sbhe_n), .isa_ior_n(isa_ior_n),
        .isa_iow_n(isa_iow_n), .isa_memr_n(isa_memr_n), .isa_memw_n(isa_memw_n),
        .isa_smemr_n(isa_smemr_n), .isa_smemw_n(isa_smemw_n),
        .isa_reset_drv(isa_reset_drv), .isa_aen(isa_aen),
        .isa_d_lo_out(isa_d_lo_out), .isa_d_lo_oe(isa_d_lo_oe), .isa_d_lo_in(isa_d_lo_in),
        .isa_d_hi_out(isa_d_hi_out), .isa_d_hi_oe(isa_d_hi_oe), .isa_d_hi_in(isa_d_hi_in),
        .isa_irq_req(isa_irq_req)
    );

    // compare one value and report a mismatch
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // return the host bus to idle at a falling edge
    task automatic bus_idle();
        @(negedge clk);
        host_sel_n = 1'b1; host_phi2 = 1'b0; host_rw = 1'b1; host_ba = 1'b1;
    endtask

    // one qualified host write cycle spanning a rising edge
    task automatic host_wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_rw = 1'b0;
        host_sel_n = 1'b0; host_phi2 = 1'b1; host_ba = 1'b1;
        bus_idle();
    endtask

    // one qualified host read cycle; data sampled before the rising edge
    task automatic host_rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rw = 1'b1;
        host_sel_n = 1'b0; host_phi2 = 1'b1; host_ba = 1'b1;
        #1 d = host_rdata;
        bus_idle();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        // reset state (R5)
        repeat (3) @(negedge clk);
        check("R5", "reset_drv in reset", {31'b0, isa_reset_drv}, 32'd1);
        check("R5", "aen in reset", {31'b0, isa_aen}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5", "reset_drv released", {31'b0, isa_reset_drv}, 32'd0);
        check("R5", "irq_n after reset", {31'b0, host_irq_n}, 32'd1);
        check("R5", "upper address after reset", {18'b0, isa_addr[21:8]}, 32'd0);
        check("R5", "outbound latch after reset", {24'b0, isa_d_hi_out}, 32'd0);
        host_rd(9'h104, rd);
        check("R5", "inbound latch after reset", {24'b0, rd}, 32'd0);

        // strobe sweep over space, legacy range and all host qualifiers (R1 R2 R9 R10)
        for (int sp = 0; sp < 2; sp++) begin
            for (int hi = 0; hi < 2; hi++) begin
                host_wr(9'h101, {sp[0], 1'b0, 1'b0, hi[0], 4'h0});
                for (int idx = 0; idx < 32; idx++) begin
                    logic live, rd_c, wr_c;
                    logic [7:0] exp_v, act_v;
                    @(negedge clk);
                    host_sel_n = idx[0]; host_ba = idx[1]; host_phi2 = idx[2];
                    host_addr = {idx[3], 8'h10}; host_rw = idx[4];
                    host_wdata = 8'(idx * 7 + 3);
                    #1;
                    live = !idx[0] && idx[1] && idx[2] && !idx[3];
                    rd_c = live && idx[4];
                    wr_c = live && !idx[4];
                    exp_v = {!(rd_c && sp[0]), !(wr_c && sp[0]),
                             !(rd_c && !sp[0]), !(wr_c && !sp[0]),
                             !(rd_c && !sp[0] && !hi[0]), !(wr_c && !sp[0] && !hi[0]),
                             wr_c, wr_c};
                    act_v = {isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n,
                             isa_smemr_n, isa_smemw_n, isa_d_lo_oe, isa_d_hi_oe};
                    check("R1/R2/R10", "strobe vector", {24'b0, act_v}, {24'b0, exp_v});
                    if (wr_c) check("R9", "low byte drive", {24'b0, isa_d_lo_out},
                                    {24'b0, 8'(idx * 7 + 3)});
                end
                bus_idle();
            end
        end

        // address assembly and byte-high enable (R3)
        host_wr(9'h100, 8'hA5);
        host_wr(9'h101, 8'h6B);
        @(negedge clk); host_addr = 9'h03C; #1;
        check("R3", "isa_addr pattern 1", {10'b0, isa_addr}, {10'b0, 6'h2B, 8'hA5, 8'h3C});
        check("R3", "sbhe set", {31'b0, isa_sbhe_n}, 32'd0);
        host_wr(9'h100, 8'h5C);
        host_wr(9'h101, 8'h15);
        @(negedge clk); host_addr = 9'h0F1; #1;
        check("R3", "isa_addr pattern 2", {10'b0, isa_addr}, {10'b0, 6'h15, 8'h5C, 8'hF1});
        check("R3", "sbhe clear", {31'b0, isa_sbhe_n}, 32'd1);

        // write-only page registers and unused offsets read zero (R4)
        host_rd(9'h100, rd); check("R4", "page lo readback", {24'b0, rd}, 32'd0);
        host_rd(9'h101, rd); check("R4", "page hi readback", {24'b0, rd}, 32'd0);
        host_rd(9'h105, rd); check("R4", "offset 0x05", {24'b0, rd}, 32'd0);
        host_rd(9'h1FF, rd); check("R4", "offset 0xFF", {24'b0, rd}, 32'd0);

        // interrupt walk over every line (R6)
        for (int k = 0; k < 11; k++) begin
            logic [15:0] e;
            @(negedge clk); isa_irq_req = 11'(1 << k);
            @(negedge clk);
            check("R6", "merged irq asserted", {31'b0, host_irq_n}, 32'd0);
            e = 16'(1 << k);
            host_rd(9'h102, rd); check("R6", "status low", {24'b0, rd}, {24'b0, e[7:0]});
            host_rd(9'h103, rd); check("R6", "status high", {24'b0, rd}, {24'b0, e[15:8]});
        end
        @(negedge clk); isa_irq_req = '0;
        @(negedge clk);
        check("R6", "merged irq released", {31'b0, host_irq_n}, 32'd1);
        host_rd(9'h102, rd); check("R6", "status cleared", {24'b0, rd}, 32'd0);

        // outbound upper byte (R7), memory space page
        host_wr(9'h101, 8'h00);
        host_wr(9'h104, 8'h5A);
        check("R7", "latch visible", {24'b0, isa_d_hi_out}, 32'h5A);
        check("R7", "no drive when idle", {31'b0, isa_d_hi_oe}, 32'd0);
        isa_d_lo_in = 8'h33;
        host_rd(9'h020, rd);
        host_wr(9'h100, 8'h12);
        host_rd(9'h104, rd);
        @(negedge clk);
        host_addr = 9'h020; host_wdata = 8'h11; host_rw = 1'b0;
        host_sel_n = 1'b0; host_phi2 = 1'b1; #1;
        check("R7", "held and driven on card write", {23'b0, isa_d_hi_oe, isa_d_hi_out}, {23'b0, 1'b1, 8'h5A});
        check("R9", "low byte on card write", {23'b0, isa_d_lo_oe, isa_d_lo_out}, {23'b0, 1'b1, 8'h11});
        bus_idle();

        // inbound upper byte and low-byte read forwarding (R8 R9)
        isa_d_hi_in = 8'hC3; isa_d_lo_in = 8'h9E;
        host_rd(9'h010, rd);
        check("R9", "card read data", {24'b0, rd}, 32'h9E);
        isa_d_hi_in = 8'h77;
        host_wr(9'h011, 8'h44);
        host_wr(9'h104, 8'h66);
        host_rd(9'h102, rd);
        host_rd(9'h104, rd);
        check("R8", "inbound held", {24'b0, rd}, 32'hC3);
        host_rd(9'h012, rd);
        host_rd(9'h104, rd);
        check("R8", "inbound recaptured", {24'b0, rd}, 32'h77);
        check("R7", "outbound rewritten", {24'b0, isa_d_hi_out}, 32'h66);
        check("R5", "aen stays low", {31'b0, isa_aen}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule